// File: doc/BRIEF.md
# Multi-Word Vector Comparator and Top-Word Scanner

This unit works on unsigned big numbers kept in a word-addressed operand RAM that lies outside it. Each number is a vector of 32-bit words, given by a base address and a length in words. The least significant word sits at the base address, and word i sits at base + i, modulo the RAM size.

The unit runs one of two operations at a time:

- **Compare** reads vectors A and B from the top word down. It reports the ordering of the two numbers as a one-hot flag code. When one vector is shorter, its missing upper words count as zero.
- **Scan** reads vector A from the top down. It finds the most significant nonzero word and reports that word's RAM address, or an all-zero flag that makes the address meaningless. On request, it also reports the position of the highest set bit inside that word, in a second status word.

The RAM has one port, gives one read per cycle, and returns data one cycle after the read strobe. A host loads the operands, pulses `start` while `busy` is low, and waits for the one-cycle `done` pulse. Results stay in their registers until the next operation that writes them.

Top module: `vec_cmp_scan`

## Requirements
- R1: A compare writes `cmp_flags` as a one-hot code: bit 0 means A equals B, bit 1 means A is below B, and bit 2 means A is above B. Both vectors are read as unsigned numbers, with word i of a vector at address base + i. Two zero-length vectors compare equal.
- R2: When the lengths differ, the words of the shorter vector at or above its length count as zero.
- R3: A compare visits word indices from max(a_len, b_len) - 1 downward and stops at the first index whose words differ. Call n the number of indices visited. `done` is high in the cycle that follows the (2n+1)-th rising edge after the edge that accepts `start`. With both lengths zero, `done` is high in the cycle right after the accepting edge.
- R4: A scan of a nonzero vector A writes `msw_stat`. Bits 10:0 hold (a_base + i) mod 2048, where i is the highest index with a nonzero word. Bits 15:11 are zero. With n words visited, `done` is high in the cycle after the (n+1)-th edge past the accepting edge.
- R5: A scan of an all-zero vector, or of a zero-length one (done right after the accepting edge), writes `msw_stat` = 16'h8000. Bit 15 is the zero flag and the address field reads 0.
- R6: A scan with `want_msb` high also writes `rem_stat`: bits 4:0 hold the position of the highest set bit of the top nonzero word, bit 15 holds the zero flag, and all other bits are 0. A zero vector gives 16'h8000. A scan with `want_msb` low leaves `rem_stat` unchanged.
- R7: `want_msb` has no effect on a compare: `rem_stat` keeps its value.
- R8: `done` is a one-cycle pulse. The result registers change only in the cycle in which `done` is high. A compare leaves `msw_stat` and `rem_stat` untouched, and a scan leaves `cmp_flags` untouched.
- R9: `start` is accepted only while `busy` is low. `busy` stays high from the accepting edge until `done`. A `start` pulse, or any change to the operands, while busy has no effect.
- R10: After reset, `busy`, `done`, `cmp_flags`, `msw_stat` and `rem_stat` are all zero.
- R11: `mem_rd` is high only while busy, and only for a word that lies inside its vector's length. The data is taken in the cycle after `mem_rd`. A compare issues one read per visited index for each vector long enough to hold that index. A scan issues one read per visited word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken while idle |
| op_scan | input | 1 | 1 selects scan of A, 0 selects compare of A and B |
| want_msb | input | 1 | Scan also reports the top set bit position |
| a_base | input | 11 | Word address of A's least significant word |
| a_len | input | 9 | Length of A in words |
| b_base | input | 11 | Word address of B's least significant word |
| b_len | input | 9 | Length of B in words |
| mem_rd | output | 1 | RAM read strobe |
| mem_addr | output | 11 | RAM word address |
| mem_rdata | input | 32 | RAM read data, valid the cycle after the strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cmp_flags | output | 3 | One-hot compare result |
| msw_stat | output | 16 | Top-word address with zero flag in bit 15 |
| rem_stat | output | 16 | Top-bit position in bits 4:0 with zero flag in bit 15 |

## Verification
Each result is due a fixed number of edges after the edge that accepts `start`. A compare takes 2n+1 edges, a scan takes n+1, and an empty operation takes none. Here n is the number of words the walk visits, which the bench's big-integer model works out from the RAM contents before launch. The monitor records the accepting edge at the half cycle where it sees `start` with `busy` low. When it sees `done`, it checks the elapsed edge count against the model's latency. At that same sample it compares all three result words and the number of reads counted since the accepting edge, so a result that arrives early, late or with extra reads is reported.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_CHK,
    ST_SCK
  } vcs_state_t;

  localparam logic [2:0] CMP_EQ = 3'b001;
  localparam logic [2:0] CMP_LT = 3'b010;
  localparam logic [2:0] CMP_GT = 3'b100;

endpackage

// File: rtl/vcs_msb_find.sv
module vcs_msb_find #(
  parameter int W    = 32,
  parameter int PW   = $clog2(W)
) (
  input  logic [W-1:0]  word,
  output logic [PW-1:0] pos,
  output logic          nonzero
);

  // Lowest index first, so the highest set bit wins.
  always_comb begin
    pos     = '0;
    nonzero = |word;
    for (int i = 0; i < W; i++) begin
      if (word[i]) pos = PW'(i);
    end
  end

endmodule

// File: rtl/vcs_word_cmp.sv
module vcs_word_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         gt
);

  assign lt = (a < b);
  assign gt = (a > b);

endmodule

// File: rtl/vcs_addr_gen.sv
module vcs_addr_gen
  import vcs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9
) (
  input  vcs_state_t        state,
  input  logic [LEN_W-1:0]  idx,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [LEN_W-1:0]  a_len,
  input  logic [LEN_W-1:0]  b_len,
  input  logic              advance,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr
);

  logic [LEN_W-1:0] nidx;
  assign nidx = idx - 1'b1;

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = a_base;
    unique case (state)
      ST_RDA: begin
        mem_addr = a_base + ADDR_W'(idx);
        mem_rd   = (idx < a_len);
      end
      ST_RDB: begin
        mem_addr = b_base + ADDR_W'(idx);
        mem_rd   = (idx < b_len);
      end
      ST_CHK: begin
        mem_addr = a_base + ADDR_W'(nidx);
        mem_rd   = advance && (nidx < a_len);
      end
      ST_SCK: begin
        mem_addr = a_base + ADDR_W'(nidx);
        mem_rd   = advance;
      end
      default: begin
        mem_rd   = 1'b0;
        mem_addr = a_base;
      end
    endcase
  end

endmodule

// File: rtl/vec_cmp_scan.sv
module vec_cmp_scan
  import vcs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_scan,
  input  logic              want_msb,
  input  logic [ADDR_W-1:0] a_base,
  input  logic [LEN_W-1:0]  a_len,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [LEN_W-1:0]  b_len,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        cmp_flags,
  output logic [STAT_W-1:0] msw_stat,
  output logic [STAT_W-1:0] rem_stat
);

  localparam int POS_W = $clog2(DATA_W);
  localparam int ZBIT  = STAT_W - 1;

  vcs_state_t        state_q;
  logic [LEN_W-1:0]  idx_q, alen_q, blen_q;
  logic [ADDR_W-1:0] abase_q, bbase_q;
  logic              scan_q, want_q;
  logic [DATA_W-1:0] worda_q;
  logic [2:0]        flags_q;
  logic [STAT_W-1:0] msw_q, rem_q;
  logic              done_q;

  logic              in_a, in_b, last, advance;
  logic              lt, gt, nonzero;
  logic [DATA_W-1:0] word_b;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  span;
  logic [STAT_W-1:0] found_stat, zero_stat, pos_stat;

  assign in_a   = (idx_q < alen_q);
  assign in_b   = (idx_q < blen_q);
  assign last   = (idx_q == '0);
  assign word_b = in_b ? mem_rdata : '0;
  assign span   = (a_len > b_len) ? a_len : b_len;

  vcs_word_cmp #(.W(DATA_W)) u_cmp (
    .a  (worda_q),
    .b  (word_b),
    .lt (lt),
    .gt (gt)
  );

  vcs_msb_find #(.W(DATA_W), .PW(POS_W)) u_msb (
    .word    (mem_rdata),
    .pos     (pos),
    .nonzero (nonzero)
  );

  always_comb begin
    unique case (state_q)
      ST_CHK:  advance = !lt && !gt && !last;
      ST_SCK:  advance = !nonzero && !last;
      default: advance = 1'b0;
    endcase
  end

  vcs_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
    .state    (state_q),
    .idx      (idx_q),
    .a_base   (abase_q),
    .b_base   (bbase_q),
    .a_len    (alen_q),
    .b_len    (blen_q),
    .advance  (advance),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
  );

  always_comb begin
    found_stat               = '0;
    found_stat[ADDR_W-1:0]   = abase_q + ADDR_W'(idx_q);
    zero_stat                = '0;
    zero_stat[ZBIT]          = 1'b1;
    pos_stat                 = '0;
    pos_stat[POS_W-1:0]      = pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      alen_q  <= '0;
      blen_q  <= '0;
      abase_q <= '0;
      bbase_q <= '0;
      scan_q  <= 1'b0;
      want_q  <= 1'b0;
      worda_q <= '0;
      flags_q <= '0;
      msw_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            abase_q <= a_base;
            bbase_q <= b_base;
            alen_q  <= a_len;
            blen_q  <= b_len;
            scan_q  <= op_scan;
            want_q  <= want_msb;
            idx_q   <= op_scan ? (a_len - 1'b1) : (span - 1'b1);
            if (op_scan ? (a_len == '0) : (span == '0)) begin
              done_q <= 1'b1;
              if (op_scan) begin
                msw_q <= zero_stat;
                if (want_msb) rem_q <= zero_stat;
              end else begin
                flags_q <= CMP_EQ;
              end
            end else begin
              state_q <= ST_RDA;
            end
          end
        end
        ST_RDA: state_q <= scan_q ? ST_SCK : ST_RDB;
        ST_RDB: begin
          worda_q <= in_a ? mem_rdata : '0;
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          if (advance) begin
            idx_q   <= idx_q - 1'b1;
            state_q <= ST_RDB;
          end else begin
            flags_q <= gt ? CMP_GT : (lt ? CMP_LT : CMP_EQ);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SCK: begin
          if (advance) begin
            idx_q <= idx_q - 1'b1;
          end else begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
            if (nonzero) begin
              msw_q <= found_stat;
              if (want_q) rem_q <= pos_stat;
            end else begin
              msw_q <= zero_stat;
              if (want_q) rem_q <= zero_stat;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign cmp_flags = flags_q;
  assign msw_stat  = msw_q;
  assign rem_stat  = rem_q;

endmodule

// File: rtl/vcs_checks.sv
module vcs_checks #(
  parameter int ADDR_W = 11,
  parameter int STAT_W = 16,
  parameter int POS_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [2:0]        cmp_flags,
  input logic [STAT_W-1:0] msw_stat,
  input logic [STAT_W-1:0] rem_stat
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(cmp_flags) && $stable(msw_stat) && $stable(rem_stat)));

  assert_flags_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_flags));

  assert_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
    msw_stat[STAT_W-1] |-> (msw_stat[ADDR_W-1:0] == '0));

  assert_msw_pad_R4: assert property (@(posedge clk) disable iff (rst)
    msw_stat[STAT_W-2:ADDR_W] == '0);

  assert_rem_pad_R6: assert property (@(posedge clk) disable iff (rst)
    rem_stat[STAT_W-2:POS_W] == '0);

  assert_read_busy_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind vec_cmp_scan vcs_checks #(
  .ADDR_W (ADDR_W),
  .STAT_W (STAT_W),
  .POS_W  ($clog2(DATA_W))
) u_vcs_checks (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_rd    (mem_rd),
  .cmp_flags (cmp_flags),
  .msw_stat  (msw_stat),
  .rem_stat  (rem_stat)
);

// File: tb/vec_cmp_scan_test.sv
module vec_cmp_scan_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, op_scan = 1'b0, want_msb = 1'b0;
  logic [10:0] a_base = '0, b_base = '0;
  logic [8:0]  a_len = '0, b_len = '0;
  logic        mem_rd, busy, done;
  logic [10:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  cmp_flags;
  logic [15:0] msw_stat, rem_stat;

  always #2 clk = ~clk;

  vec_cmp_scan uut (
    .clk(clk), .rst(rst), .start(start), .op_scan(op_scan), .want_msb(want_msb),
    .a_base(a_base), .a_len(a_len), .b_base(b_base), .b_len(b_len),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .cmp_flags(cmp_flags),
    .msw_stat(msw_stat), .rem_stat(rem_stat)
  );

  logic [31:0] ram [0:2047];
  always @(posedge clk) if (mem_rd) mem_rdata <= ram[mem_addr];

  int nchecks = 0, nerr = 0, edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  typedef struct {
    logic [2:0]  flags;
    logic [15:0] msw;
    logic [15:0] rem;
    int          lat;
    int          reads;
    bit          scan;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [2:0]  m_flags = '0;
  logic [15:0] m_msw = '0, m_rem = '0;

  function automatic logic [31:0] rword(input int base, input int i, input int len);
    if (i >= len) return 32'h0;
    return ram[11'(base + i)];
  endfunction

  // Scoreboard monitor, sampling on the falling edge
  int   accept_edge = 0, rd_cnt = 0;
  bit   armed = 0;
  exp_t e;
  always @(negedge clk) begin
    if (!rst) begin
      if (armed && mem_rd) rd_cnt++;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'(done), 32'h0);
        end else begin
          e = q.pop_front();
          chk(cmp_flags == e.flags, {"R1 flags ", e.tag}, 32'(cmp_flags), 32'(e.flags));
          chk(msw_stat == e.msw, {"R4 msw ", e.tag}, 32'(msw_stat), 32'(e.msw));
          chk(rem_stat == e.rem, {"R6 rem ", e.tag}, 32'(rem_stat), 32'(e.rem));
          chk(edge_n - accept_edge == e.lat, e.scan ? {"R4 latency ", e.tag} : {"R3 latency ", e.tag},
              32'(edge_n - accept_edge), 32'(e.lat));
          chk(rd_cnt == e.reads, {"R11 reads ", e.tag}, 32'(rd_cnt), 32'(e.reads));
        end
        armed = 0;
      end
      if (start && !busy && !armed) begin
        accept_edge = edge_n + 1;
        armed = 1;
        rd_cnt = 0;
      end
    end
  end

  task automatic launch(input bit sc, input bit wm, input int ab, input int al, input int bb, input int bl);
    @(posedge clk); #1;
    op_scan = sc; want_msb = wm;
    a_base = 11'(ab); a_len = 9'(al); b_base = 11'(bb); b_len = 9'(bl);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic push_exp(input bit sc, input bit wm, input int ab, input int al, input int bb, input int bl, input string tag);
    exp_t x;
    int n = 0, reads = 0, pos = 0;
    bit found = 0;
    logic [31:0] wa, wb, w;
    if (!sc) begin
      int span = (al > bl) ? al : bl;
      m_flags = 3'b001;
      for (int i = span - 1; i >= 0; i--) begin
        n++;
        reads += (i < al) + (i < bl);
        wa = rword(ab, i, al);
        wb = rword(bb, i, bl);
        if (wa > wb) begin m_flags = 3'b100; break; end
        if (wa < wb) begin m_flags = 3'b010; break; end
      end
      x.lat = (span == 0) ? 0 : 2 * n + 1;
    end else begin
      for (int i = al - 1; i >= 0; i--) begin
        n++;
        w = rword(ab, i, al);
        if (w != 0) begin
          found = 1;
          m_msw = {5'b0, 11'(ab + i)};
          for (int k = 0; k < 32; k++) if (w[k]) pos = k;
          break;
        end
      end
      if (!found) m_msw = 16'h8000;
      if (wm) m_rem = found ? 16'(pos) : 16'h8000;
      reads = n;
      x.lat = (al == 0) ? 0 : n + 1;
    end
    x.flags = m_flags; x.msw = m_msw; x.rem = m_rem;
    x.reads = reads; x.scan = sc; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run_op(input bit sc, input bit wm, input int ab, input int al, input int bb, input int bl, input string tag);
    push_exp(sc, wm, ab, al, bb, bl, tag);
    launch(sc, wm, ab, al, bb, bl);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) ram[i] = 32'h0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10: reset values
    chk(!busy && !done, "R10 busy/done", {30'b0, busy, done}, 32'h0);
    chk(cmp_flags == 3'b0 && msw_stat == 16'h0 && rem_stat == 16'h0, "R10 results",
        {13'b0, cmp_flags, msw_stat}, 32'h0);

    // Compare: equal vectors, then a low-word-only difference, then a top-word one
    for (int i = 0; i < 4; i++) begin ram[16 + i] = 32'h1111_0000 + i; ram[64 + i] = 32'h1111_0000 + i; end
    run_op(0, 0, 16, 4, 64, 4, "R1 equal");
    ram[16] = 32'h5; ram[64] = 32'h6;
    run_op(0, 0, 16, 4, 64, 4, "R3 lowest word");
    ram[19] = 32'hFFFF_0000;
    run_op(0, 0, 16, 4, 64, 4, "R3 top word");

    // Unequal lengths with zero extension
    for (int i = 0; i < 8; i++) begin ram[16 + i] = 0; ram[64 + i] = 0; end
    ram[16] = 7; ram[17] = 8; ram[18] = 9;
    ram[64] = 7; ram[65] = 8; ram[66] = 9;
    ram[19] = 32'hDEAD; // beyond A's length, must be ignored
    run_op(0, 0, 16, 3, 64, 5, "R2 shorter A equal");
    ram[68] = 1;
    run_op(0, 0, 16, 3, 64, 5, "R2 longer B above");
    ram[21] = 2;
    run_op(0, 0, 16, 6, 64, 2, "R2 longer A above");
    run_op(0, 0, 16, 0, 64, 0, "R1 both empty");

    // Scan
    for (int i = 0; i < 6; i++) ram[256 + i] = 0;
    ram[256] = 3; ram[258] = 32'h0040_0000;
    run_op(1, 1, 256, 6, 0, 0, "R4 top word idx2");
    run_op(1, 1, 300, 4, 0, 0, "R5 all zero");
    ram[256 + 5] = 32'h1;
    run_op(1, 1, 256, 6, 0, 0, "R6 bit zero");
    ram[512] = 32'h8000_0000;
    run_op(1, 1, 512, 1, 0, 0, "R6 bit 31");
    run_op(1, 0, 256, 3, 0, 0, "R6 no request keeps rem");
    run_op(1, 0, 400, 0, 0, 0, "R5 empty");
    run_op(0, 1, 16, 6, 64, 5, "R7 compare ignores request");
    ram[2046] = 0; ram[2047] = 0; ram[0] = 1; ram[1] = 0;
    run_op(1, 1, 2046, 4, 0, 0, "R4 address wrap");

    // R9: a start pulse while busy, with other operands, is ignored
    for (int i = 0; i < 4; i++) begin ram[16 + i] = 32'hA0 + i; ram[64 + i] = 32'hA0 + i; end
    push_exp(0, 0, 16, 4, 64, 4, "R9 first op");
    launch(0, 0, 16, 4, 64, 4);
    @(posedge clk); #1;
    op_scan = 1; want_msb = 1; a_base = 11'd512; a_len = 9'd1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!busy, "R9 no second launch", 32'(busy), 32'h0);

    // R8: mixed random operations
    for (int t = 0; t < 24; t++) begin
      int ab = 32 * (t + 40);
      int bb = ab + 16;
      int al = $urandom_range(0, 6);
      int bl = $urandom_range(0, 6);
      for (int i = 0; i < 8; i++) begin
        ram[11'(ab + i)] = ($urandom_range(0, 2) == 0) ? 32'h0 : (32'h1 << $urandom_range(0, 31));
        ram[11'(bb + i)] = ram[11'(ab + i)];
      end
      if ($urandom_range(0, 1) == 1) ram[11'(bb + $urandom_range(0, 5))] = $urandom;
      run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ab, al, bb, bl, "R8 random");
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule